// File: doc/BRIEF.md
# Write-Protection Key Gate with Initialization Handshake

This block stands in front of a calendar unit's configuration registers (control, prescaler, time, date and alarm) and decides whether a bus write may reach them. After reset every such write is blocked. Software opens the gate by writing two fixed key bytes in a fixed order to a dedicated key address. Any other byte written to that address shuts the gate again. The block drives a one-bit qualifier that the protected registers use as their write enable.

The block also keeps the handshake flags that software polls while it reprograms the calendar. An initialization-request bit, once set, brings up an initialization-ready flag after two cycles of the slow calendar clock. A resynchronization flag announces that the calendar shadow copies are fresh. Software clears it, and it comes back two slow cycles later, but it stays low for as long as initialization mode is active. A sticky flag records that the calendar year has been programmed to a nonzero value. The slow clock is seen as a one-cycle strobe in the bus clock domain.

Top module: `key_gate_top`

## Requirements
- R1: After reset the gate is locked, `protWrEn` is low and all status bits are 0.
- R2: A write of 0xCA to the key address (6) followed by a write of 0x53 as the very next key-address write opens the gate (`isUnlocked` = 1).
- R3: A key-address write of any byte other than 0xCA or 0x53 (0xFF for example) closes the gate on the next cycle.
- R4: A 0x53 key write that does not directly follow a 0xCA key write leaves the gate closed and restarts the sequence. A 0xCA followed by another 0xCA and then 0x53 opens it.
- R5: While the gate is closed, writes to the protected addresses give `protWrEn` = 0, and writes to the status address (5) change no status bit.
- R6: `protWrEn` is high only for a write to addresses 0 to 4 while the gate is open. It stays low for the status address, the key address and all other addresses.
- R7: A status write with bit 7 = 1 sets the init-request bit (status bit 7). The init-ready bit (status bit 6) rises after the second following slow strobe and not after the first.
- R8: A status write with bit 7 = 0 clears status bits 7 and 6 together, visible on the next cycle.
- R9: A status write with bit 5 = 0 clears the resync flag (status bit 5). It sets again after the second following slow strobe. A status write with bit 5 = 1 does not set it.
- R10: While the init-request bit is set, the resync flag stays 0 regardless of slow strobes.
- R11: Status bit 4 becomes 1 once `calYearNz` has been seen high. It then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low power-on reset |
| slowTick | input | 1 | One-cycle pulse per slow calendar clock cycle |
| busWr | input | 1 | Bus write strobe |
| busAddr | input | ADDR_W | Word address of the write |
| busWdata | input | DATA_W | Write data |
| calYearNz | input | 1 | High while the calendar year field is nonzero |
| protWrEn | output | 1 | Write enable for the protected registers at addresses 0 to 4 |
| isUnlocked | output | 1 | Gate open |
| statusBits | output | 8 | Bit 7 init request, bit 6 init ready, bit 5 resync, bit 4 calendar set, others 0 |

## Verification
The bench goes after the key ordering. It sends 0x53 with no 0xCA before it, puts a foreign byte between the two keys, and repeats 0xCA before 0x53. A gate that remembered a stale first key would open in the second case, and one that reset on a repeated 0xCA would stay shut in the third. It counts slow strobes exactly and checks that the ready and resync flags are still low after one strobe and high after two, which catches an off-by-one settle counter. It also writes the status register while locked and while in init mode. A gate that leaked status writes, or a resync flag that kept counting during initialization, shows up as a wrong status byte.

// File: rtl/key_gate_pkg.sv
package key_gate_pkg;

  localparam int BIT_INIT_REQ = 7;
  localparam int BIT_INIT_RDY = 6;
  localparam int BIT_SYNC     = 5;
  localparam int BIT_CAL_SET  = 4;

  typedef enum logic [1:0] {
    KEY_LOCKED = 2'd0,
    KEY_HALF   = 2'd1,
    KEY_OPEN   = 2'd2
  } keyState_e;

  typedef struct packed {
    logic setInit;
    logic clrInit;
    logic clrSync;
  } gateStb_t;

endpackage

// File: rtl/key_gate_ctrl.sv
module key_gate_ctrl
  import key_gate_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int NUM_PROT    = 5,
  parameter int STATUS_ADDR = 5,
  parameter int KEY_ADDR    = 6,
  parameter logic [DATA_W-1:0] KEY_FIRST  = 8'hCA,
  parameter logic [DATA_W-1:0] KEY_SECOND = 8'h53
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output gateStb_t          stb,
  output logic              isUnlocked,
  output logic              protWrEn
);

  localparam logic [ADDR_W-1:0] PROT_LIMIT = ADDR_W'(NUM_PROT);
  localparam logic [ADDR_W-1:0] STAT_A     = ADDR_W'(STATUS_ADDR);
  localparam logic [ADDR_W-1:0] KEY_A      = ADDR_W'(KEY_ADDR);

  keyState_e keyState, keyNext;
  logic keyWr, statWr;

  assign keyWr  = busWr && (busAddr == KEY_A);
  assign statWr = busWr && (busAddr == STAT_A) && (keyState == KEY_OPEN);

  always_comb begin
    keyNext = keyState;
    if (keyWr) begin
      if (busWdata == KEY_FIRST)
        keyNext = KEY_HALF;
      else if (busWdata == KEY_SECOND && keyState == KEY_HALF)
        keyNext = KEY_OPEN;
      else
        keyNext = KEY_LOCKED;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) keyState <= KEY_LOCKED;
    else       keyState <= keyNext;
  end

  assign isUnlocked  = (keyState == KEY_OPEN);
  assign protWrEn    = busWr && isUnlocked && (busAddr < PROT_LIMIT);
  assign stb.setInit = statWr && busWdata[BIT_INIT_REQ];
  assign stb.clrInit = statWr && !busWdata[BIT_INIT_REQ];
  assign stb.clrSync = statWr && !busWdata[BIT_SYNC];

  // R2 / R4: opening only ever follows the second key right after the first
  assert_open_needs_pair_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(isUnlocked) |-> $past(keyWr && busWdata == KEY_SECOND && keyState == KEY_HALF));

  // R3: a foreign key byte always closes the gate
  assert_wrong_key_locks_R3: assert property (@(posedge clk) disable iff (!rstN)
    (keyWr && busWdata != KEY_FIRST && busWdata != KEY_SECOND) |=> !isUnlocked);

  // R6: qualifier never reaches status or key addresses
  assert_no_prot_on_ctl_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && (busAddr == STAT_A || busAddr == KEY_A)) |-> !protWrEn);

endmodule

// File: rtl/key_gate_flags.sv
module key_gate_flags
  import key_gate_pkg::*;
#(
  parameter int SETTLE_TICKS = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  gateStb_t stb,
  input  logic     slowTick,
  input  logic     calYearNz,
  output logic [7:0] statusBits
);

  localparam int CNT_W = $clog2(SETTLE_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SETTLE_TICKS - 1);

  logic initReq, initRdy, syncFlag, calSet;
  logic [CNT_W-1:0] initCnt, syncCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initReq <= 1'b0;
      initRdy <= 1'b0;
      initCnt <= '0;
    end else if (stb.clrInit) begin
      initReq <= 1'b0;
      initRdy <= 1'b0;
      initCnt <= '0;
    end else begin
      if (stb.setInit) initReq <= 1'b1;
      if (initReq && !initRdy && slowTick) begin
        if (initCnt == LAST_CNT) initRdy <= 1'b1;
        initCnt <= initCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncFlag <= 1'b0;
      syncCnt  <= '0;
    end else if (initReq || stb.setInit || stb.clrSync) begin
      syncFlag <= 1'b0;
      syncCnt  <= '0;
    end else if (!syncFlag && slowTick) begin
      if (syncCnt == LAST_CNT) syncFlag <= 1'b1;
      syncCnt <= syncCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          calSet <= 1'b0;
    else if (calYearNz) calSet <= 1'b1;
  end

  always_comb begin
    statusBits = '0;
    statusBits[BIT_INIT_REQ] = initReq;
    statusBits[BIT_INIT_RDY] = initRdy;
    statusBits[BIT_SYNC]     = syncFlag;
    statusBits[BIT_CAL_SET]  = calSet;
  end

  // R7: ready rises only on a slow strobe while requested
  assert_ready_on_tick_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(initRdy) |-> (initReq && $past(slowTick)));

  // R8: leaving init mode drops ready together with request
  assert_exit_clears_ready_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(initReq) |-> !initRdy);

  // R9: resync flag comes back only on a slow strobe
  assert_sync_on_tick_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(syncFlag) |-> $past(slowTick));

  // R10: resync held low during init mode
  assert_sync_low_in_init_R10: assert property (@(posedge clk) disable iff (!rstN)
    initReq |=> !syncFlag);

  // R11: calendar-set flag is sticky
  assert_cal_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    calSet |=> calSet);

endmodule

// File: rtl/key_gate_top.sv
module key_gate_top
  import key_gate_pkg::*;
#(
  parameter int ADDR_W       = 4,
  parameter int DATA_W       = 8,
  parameter int NUM_PROT     = 5,
  parameter int STATUS_ADDR  = 5,
  parameter int KEY_ADDR     = 6,
  parameter int SETTLE_TICKS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slowTick,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              calYearNz,
  output logic              protWrEn,
  output logic              isUnlocked,
  output logic [7:0]        statusBits
);

  gateStb_t stb;

  key_gate_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PROT(NUM_PROT),
    .STATUS_ADDR(STATUS_ADDR), .KEY_ADDR(KEY_ADDR)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .stb(stb), .isUnlocked(isUnlocked),
    .protWrEn(protWrEn)
  );

  key_gate_flags #(.SETTLE_TICKS(SETTLE_TICKS)) uFlags (
    .clk(clk), .rstN(rstN), .stb(stb), .slowTick(slowTick),
    .calYearNz(calYearNz), .statusBits(statusBits)
  );

  // R5: while locked the status register cannot change except by strobes/year input
  assert_locked_no_init_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!isUnlocked && !statusBits[7]) |=> !statusBits[7]);

endmodule

// File: tb/tb_key_gate_top.sv
module tb_key_gate_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic slowTick = 1'b0;
  logic busWr = 1'b0;
  logic [3:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic calYearNz = 1'b0;
  logic protWrEn, isUnlocked;
  logic [7:0] statusBits;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    int       sel;     // 0 unlocked, 1 protWrEn, 2 status
    logic [7:0] exp;
    string    req;
  } item_t;
  item_t q[$];

  always #5 clk = ~clk;

  key_gate_top dut (
    .clk(clk), .rstN(rstN), .slowTick(slowTick), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .calYearNz(calYearNz),
    .protWrEn(protWrEn), .isUnlocked(isUnlocked), .statusBits(statusBits)
  );

  task automatic cyc(input logic w, input logic [3:0] a, input logic [7:0] d, input logic t);
    @(negedge clk);
    busWr = w; busAddr = a; busWdata = d; slowTick = t;
  endtask

  task automatic idle();
    cyc(1'b0, 4'd0, 8'h00, 1'b0);
  endtask

  task automatic tick();
    cyc(1'b0, 4'd0, 8'h00, 1'b1);
  endtask

  task automatic expect_item(input int sel, input logic [7:0] v, input string r);
    item_t it;
    it.sel = sel; it.exp = v; it.req = r;
    q.push_back(it);
  endtask

  // monitor: compares queued expectations shortly after each driving edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = q.pop_front();
        case (it.sel)
          0: act = {7'd0, isUnlocked};
          1: act = {7'd0, protWrEn};
          default: act = statusBits;
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
        end
      end
    end
  end

  initial begin
    int cnt = 0;
    while (!done && cnt < 5000) begin
      @(posedge clk);
      cnt++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle();
    expect_item(0, 8'h00, "R1 locked after reset");
    expect_item(1, 8'h00, "R1 no qualifier after reset");
    expect_item(2, 8'h00, "R1 status zero after reset");

    // R5: locked writes ignored
    cyc(1, 4'd2, 8'h12, 0);
    expect_item(1, 8'h00, "R5 locked protected write");
    cyc(1, 4'd5, 8'h80, 0);
    idle();
    expect_item(2, 8'h00, "R5 locked status write ignored");

    // R2: unlock
    cyc(1, 4'd6, 8'hCA, 0);
    cyc(1, 4'd6, 8'h53, 0);
    idle();
    expect_item(0, 8'h01, "R2 unlocked after key pair");
    cyc(1, 4'd0, 8'h01, 0);
    expect_item(1, 8'h01, "R6 address 0 qualified");
    cyc(1, 4'd4, 8'h01, 0);
    expect_item(1, 8'h01, "R6 address 4 qualified");
    cyc(1, 4'd5, 8'h20, 0);
    expect_item(1, 8'h00, "R6 status address not qualified");
    cyc(1, 4'd7, 8'h00, 0);
    expect_item(1, 8'h00, "R6 address 7 not qualified");

    // R3: wrong key relocks
    cyc(1, 4'd6, 8'hFF, 0);
    idle();
    expect_item(0, 8'h00, "R3 wrong key locks");
    cyc(1, 4'd1, 8'h00, 0);
    expect_item(1, 8'h00, "R3 qualifier off after relock");

    // R4: ordering
    cyc(1, 4'd6, 8'h53, 0);
    idle();
    expect_item(0, 8'h00, "R4 lone second key");
    cyc(1, 4'd6, 8'hCA, 0);
    cyc(1, 4'd6, 8'h11, 0);
    cyc(1, 4'd6, 8'h53, 0);
    idle();
    expect_item(0, 8'h00, "R4 interrupted sequence");
    cyc(1, 4'd6, 8'hCA, 0);
    cyc(1, 4'd6, 8'hCA, 0);
    cyc(1, 4'd6, 8'h53, 0);
    idle();
    expect_item(0, 8'h01, "R4 repeated first key restarts");

    // R9: resync flag after two strobes
    tick();
    idle();
    expect_item(2, 8'h00, "R9 resync low after one strobe");
    tick();
    idle();
    expect_item(2, 8'h20, "R9 resync high after two strobes");
    cyc(1, 4'd5, 8'h00, 0);
    idle();
    expect_item(2, 8'h00, "R9 resync cleared by write 0");
    cyc(1, 4'd5, 8'h20, 0);
    idle();
    expect_item(2, 8'h00, "R9 write 1 does not set resync");
    tick();
    idle();
    expect_item(2, 8'h00, "R9 still low after one strobe");
    tick();
    idle();
    expect_item(2, 8'h20, "R9 back after two strobes");

    // R7: init handshake
    cyc(1, 4'd5, 8'h80, 0);
    idle();
    expect_item(2, 8'h80, "R7 request set, resync dropped");
    tick();
    idle();
    expect_item(2, 8'h80, "R7 not ready after one strobe");
    tick();
    idle();
    expect_item(2, 8'hC0, "R7 ready after two strobes");
    tick();
    tick();
    idle();
    expect_item(2, 8'hC0, "R10 resync held low in init");

    // R8: exit
    cyc(1, 4'd5, 8'h00, 0);
    idle();
    expect_item(2, 8'h00, "R8 exit clears request and ready");
    tick();
    tick();
    idle();
    expect_item(2, 8'h20, "R9 resync back after exit");

    // R5: locked status write ignored with nonzero state
    cyc(1, 4'd6, 8'hFF, 0);
    cyc(1, 4'd5, 8'h80, 0);
    idle();
    expect_item(2, 8'h20, "R5 locked status write ignored");

    // R11
    cyc(0, 4'd0, 8'h00, 0);
    calYearNz = 1'b1;
    idle();
    calYearNz = 1'b0;
    expect_item(2, 8'h30, "R11 calendar set flag");
    idle();
    idle();
    expect_item(2, 8'h30, "R11 calendar set flag sticky");

    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    idle();
    expect_item(2, 8'h00, "R1 status zero after second reset");
    expect_item(0, 8'h00, "R1 locked after second reset");

    idle();
    idle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule